// File: doc/BRIEF.md
# Exception Cause and Redirect Unit

This block sits beside a simple in-order processor pipeline and turns exception conditions raised by the current instruction into a change of control flow. The pipeline presents a vector of condition flags and the address of the instruction in its last stage register. When a flag is raised, the unit records a cause code and a return address. In the same cycle it steers the fetch address to one fixed handler entry point.

Six conditions are supported: arithmetic overflow, undefined opcode, privileged instruction, store to a read-only region, access to an absent region, and a debug trap. The first five are restartable errors. For these the saved address is that of the offending instruction, so it can be retried. The trap fires after the instruction completes. For the trap the saved address is the incremented PC.

While the handler runs, a busy flag shields the saved state from being overwritten. A return strobe then sends fetch back to the saved address and clears the flag. The control FSM has two states, `ST_RUN` and `ST_HANDLER`, and two transitions:
- take (`ST_RUN` to `ST_HANDLER`), when any condition flag is high;
- return (`ST_HANDLER` to `ST_RUN`), when the return strobe is high.

Top module: `exc_redirect_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_handler`, `cause` and `epc` are 0, `redirect` is 0 and `fetch_addr` equals `fetch_in`, given no condition flags.
- R2: In `ST_RUN` with no condition flag raised, `fetch_addr` follows `fetch_in` and `redirect` is 0.
- R3: In `ST_RUN`, any raised bit of `cond` makes `redirect` 1 and `fetch_addr` equal 0x40000040 in that same cycle, and `in_handler` is 1 from the next cycle.
- R4: Bit i of `cond` carries cause code i: 0 overflow, 1 undefined opcode, 2 privileged instruction, 3 read-only store, 4 absent region, 5 debug trap. When several bits are raised together, the lowest raised index is stored in `cause` at the next edge.
- R5: When the stored code is 0 to 4, `epc` takes the `pc_cur` of the cycle in which the exception was taken.
- R6: When the stored code is 5, `epc` takes that `pc_cur` plus 4.
- R7: In `ST_HANDLER` without a return strobe, condition flags are ignored: `redirect` is 0, `fetch_addr` follows `fetch_in`, and `cause` and `epc` keep their values.
- R8: In `ST_HANDLER`, a high `eret` makes `fetch_addr` equal `epc` and `redirect` 1 for that cycle, and `in_handler` is 0 from the next cycle.
- R9: In `ST_RUN` with no condition flag, `eret` has no effect: `redirect` stays 0, `fetch_addr` follows `fetch_in` and `in_handler` stays 0.
- R10: In `ST_HANDLER`, when `eret` and condition flags arrive together, the return wins. `cause` and `epc` remain unchanged, and the unit is in `ST_RUN` next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_cur | input | 32 | Address of the instruction in the last pipeline stage register |
| fetch_in | input | 32 | Fetch address the pipeline would use without intervention |
| cond | input | 6 | Exception condition flags, bit index equals cause code |
| eret | input | 1 | Return-from-exception strobe |
| fetch_addr | output | 32 | Fetch address to use this cycle |
| redirect | output | 1 | High when `fetch_addr` is overridden |
| cause | output | 3 | Stored cause code |
| epc | output | 32 | Stored return address |
| in_handler | output | 1 | High while in `ST_HANDLER` |

## Verification
Two events can coincide in one cycle: a new exception being raised and the return from the current one. The random stimulus drives `cond` and `eret` independently, and directed steps force both high in `ST_HANDLER` and also in `ST_RUN`. The bench model lets the return win in the handler and the take win outside it. It judges the outcome by the fetch address in that cycle, and by `cause`, `epc` and `in_handler` in the cycle after.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int unsigned NCAUSE = 6;
    localparam int unsigned CW     = $clog2(NCAUSE);

    typedef enum logic [CW-1:0] {
        C_OVF    = 3'd0,
        C_UNDEF  = 3'd1,
        C_PRIV   = 3'd2,
        C_ROWR   = 3'd3,
        C_ABSENT = 3'd4,
        C_TRAP   = 3'd5
    } cause_e;

    typedef enum logic {
        ST_RUN,
        ST_HANDLER
    } state_e;
endpackage

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
    parameter int unsigned N = 6,
    parameter int unsigned W = 3
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    logic [N-1:0] below;

    // below[g] is high when some lower-index request is raised
    generate
        for (genvar g = 0; g < N; g++) begin : g_below
            if (g == 0) begin : g_first
                assign below[g] = 1'b0;
            end else begin : g_rest
                assign below[g] = below[g-1] | req[g-1];
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !below[i]) idx = W'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/exc_epc_sel.sv
module exc_epc_sel #(
    parameter int unsigned AW          = 32,
    parameter int unsigned CW          = 3,
    parameter int unsigned INSTR_BYTES = 4,
    parameter int unsigned TRAP_CODE   = 5
) (
    input  logic [AW-1:0] pc_cur,
    input  logic [CW-1:0] code,
    output logic [AW-1:0] save_pc
);
    localparam logic [AW-1:0] STEP = AW'(INSTR_BYTES);

    // traps resume after the instruction; all other causes retry it
    always_comb begin
        if (code == CW'(TRAP_CODE)) save_pc = pc_cur + STEP;
        else                        save_pc = pc_cur;
    end
endmodule

// File: rtl/exc_ctrl_fsm.sv
module exc_ctrl_fsm
    import exc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   any_cond,
    input  logic   eret,
    output state_e state,
    output logic   take,
    output logic   ret
);
    state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        take    = 1'b0;
        ret     = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (any_cond) begin
                    take    = 1'b1;
                    state_d = ST_HANDLER;
                end
            end
            ST_HANDLER: begin
                if (eret) begin
                    ret     = 1'b1;
                    state_d = ST_RUN;
                end
            end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/exc_redirect_unit.sv
module exc_redirect_unit
    import exc_pkg::*;
#(
    parameter int unsigned     AW           = 32,
    parameter logic [AW-1:0]   HANDLER_ADDR = 32'h4000_0040,
    parameter int unsigned     INSTR_BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     pc_cur,
    input  logic [AW-1:0]     fetch_in,
    input  logic [NCAUSE-1:0] cond,
    input  logic              eret,
    output logic [AW-1:0]     fetch_addr,
    output logic              redirect,
    output logic [CW-1:0]     cause,
    output logic [AW-1:0]     epc,
    output logic              in_handler
);
    logic          any_cond;
    logic [CW-1:0] win_code;
    logic [AW-1:0] save_pc;
    logic          take, ret;
    state_e        state;
    logic [CW-1:0] cause_q;
    logic [AW-1:0] epc_q;

    exc_prio_enc #(.N(NCAUSE), .W(CW)) u_prio (
        .req (cond),
        .any (any_cond),
        .idx (win_code)
    );

    exc_epc_sel #(
        .AW(AW), .CW(CW), .INSTR_BYTES(INSTR_BYTES), .TRAP_CODE(int'(C_TRAP))
    ) u_epc (
        .pc_cur  (pc_cur),
        .code    (win_code),
        .save_pc (save_pc)
    );

    exc_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_cond (any_cond),
        .eret     (eret),
        .state    (state),
        .take     (take),
        .ret      (ret)
    );

    // saved state is written only on the take transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else if (take) begin
            cause_q <= win_code;
            epc_q   <= save_pc;
        end
    end

    always_comb begin
        fetch_addr = fetch_in;
        redirect   = 1'b0;
        if (take) begin
            fetch_addr = HANDLER_ADDR;
            redirect   = 1'b1;
        end else if (ret) begin
            fetch_addr = epc_q;
            redirect   = 1'b1;
        end
    end

    assign cause      = cause_q;
    assign epc        = epc_q;
    assign in_handler = (state == ST_HANDLER);
endmodule

// File: rtl/exc_redirect_chk.sv
module exc_redirect_chk
    import exc_pkg::*;
#(
    parameter int unsigned   AW           = 32,
    parameter logic [AW-1:0] HANDLER_ADDR = 32'h4000_0040,
    parameter int unsigned   INSTR_BYTES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     pc_cur,
    input logic [AW-1:0]     fetch_in,
    input logic [NCAUSE-1:0] cond,
    input logic              eret,
    input logic [AW-1:0]     fetch_addr,
    input logic              redirect,
    input logic [CW-1:0]     cause,
    input logic [AW-1:0]     epc,
    input logic              in_handler
);
    a_r3_take_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && |cond) |-> (redirect && fetch_addr == HANDLER_ADDR));

    a_r3_enter_handler: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && |cond) |=> in_handler);

    a_r4_lowest_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && |cond) |=>
            ((($past(cond) >> cause) & NCAUSE'(1)) != '0) &&
            (($past(cond) & ((NCAUSE'(1) << cause) - NCAUSE'(1))) == '0));

    a_r5_fault_epc: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && |cond[4:0]) |=> (epc == $past(pc_cur)));

    a_r6_trap_epc: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && cond == 6'b100000) |=>
            (epc == $past(pc_cur) + AW'(INSTR_BYTES)));

    a_r7_hold_saved: assert property (@(posedge clk) disable iff (!rst_n)
        in_handler |=> ($stable(epc) && $stable(cause)));

    a_r7_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler && !eret) |-> (!redirect && fetch_addr == fetch_in));

    a_r8_return_target: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler && eret) |-> (redirect && fetch_addr == epc));

    a_r8_leave_handler: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler && eret) |=> !in_handler);

    a_r9_stray_return: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && !(|cond)) |-> (!redirect && fetch_addr == fetch_in));
endmodule

bind exc_redirect_unit exc_redirect_chk #(
    .AW(AW), .HANDLER_ADDR(HANDLER_ADDR), .INSTR_BYTES(INSTR_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pc_cur(pc_cur), .fetch_in(fetch_in),
    .cond(cond), .eret(eret), .fetch_addr(fetch_addr), .redirect(redirect),
    .cause(cause), .epc(epc), .in_handler(in_handler)
);

// File: tb/exc_redirect_unit_tb.sv
module exc_redirect_unit_tb;
    import exc_pkg::*;

    localparam logic [31:0] H_ADDR = 32'h4000_0040;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [31:0]       pc_cur, fetch_in;
    logic [NCAUSE-1:0] cond;
    logic              eret;
    logic [31:0]       fetch_addr, epc;
    logic              redirect, in_handler;
    logic [CW-1:0]     cause;

    int n_cmp = 0;
    int n_bad = 0;

    logic        m_inh;
    logic [2:0]  m_cause;
    logic [31:0] m_epc;

    always #2 clk = ~clk;

    exc_redirect_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pc_cur(pc_cur), .fetch_in(fetch_in),
        .cond(cond), .eret(eret), .fetch_addr(fetch_addr), .redirect(redirect),
        .cause(cause), .epc(epc), .in_handler(in_handler)
    );

    function automatic logic [2:0] lowest(input logic [NCAUSE-1:0] c);
        for (int i = 0; i < NCAUSE; i++) if (c[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive at negedge, check shortly after, update model at posedge
    task automatic step(input logic [31:0] pc, input logic [31:0] fi,
                        input logic [NCAUSE-1:0] c, input logic er);
        string rq;
        logic [31:0] e_fa;
        logic        e_rd;
        @(negedge clk);
        pc_cur = pc; fetch_in = fi; cond = c; eret = er;
        #1;
        if (!m_inh && |c) begin
            rq = "R3"; e_fa = H_ADDR; e_rd = 1'b1;
        end else if (m_inh && er) begin
            rq = (|c) ? "R10" : "R8"; e_fa = m_epc; e_rd = 1'b1;
        end else begin
            rq = m_inh ? "R7" : (er ? "R9" : "R2");
            e_fa = fi; e_rd = 1'b0;
        end
        chk(rq, "fetch_addr", fetch_addr, e_fa);
        chk(rq, "redirect", 32'(redirect), 32'(e_rd));
        chk(rq, "in_handler", 32'(in_handler), 32'(m_inh));
        chk("R4", "cause", 32'(cause), 32'(m_cause));
        chk((m_cause == 3'd5) ? "R6" : "R5", "epc", epc, m_epc);
        @(posedge clk);
        if (!m_inh && |c) begin
            m_cause = lowest(c);
            m_epc   = (m_cause == 3'd5) ? pc + 32'd4 : pc;
            m_inh   = 1'b1;
        end else if (m_inh && er) begin
            m_inh = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        rst_n = 1'b0; pc_cur = '0; fetch_in = 32'h100; cond = '0; eret = 1'b0;
        m_inh = 1'b0; m_cause = '0; m_epc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "in_handler", 32'(in_handler), 0);
        chk("R1", "cause", 32'(cause), 0);
        chk("R1", "epc", epc, 0);
        chk("R1", "redirect", 32'(redirect), 0);
        chk("R1", "fetch_addr", fetch_addr, 32'h100);
        rst_n = 1'b1;

        // directed: idle, stray return, trap, simultaneous events
        step(32'h200, 32'h204, 6'b000000, 1'b0);  // R2
        step(32'h204, 32'h208, 6'b000000, 1'b1);  // R9
        step(32'h300, 32'h304, 6'b100000, 1'b0);  // R3, R6
        step(32'h500, 32'h504, 6'b001000, 1'b0);  // R7 ignored
        step(32'h504, 32'h508, 6'b000000, 1'b1);  // R8
        step(32'h600, 32'h604, 6'b110100, 1'b1);  // R4 lowest=2, eret ignored in run
        step(32'h700, 32'h704, 6'b000011, 1'b1);  // R10 return wins
        step(32'h704, 32'h708, 6'b000000, 1'b0);  // R2 back in run
        step(32'h800, 32'h804, 6'b111111, 1'b0);  // R4 code 0, R5
        step(32'h804, 32'h808, 6'b000000, 1'b1);  // R8
        step(32'h900, 32'h904, 6'b110000, 1'b0);  // code 4, R5
        step(32'h904, 32'h908, 6'b000000, 1'b1);

        for (int k = 0; k < 3000; k++) begin
            logic [NCAUSE-1:0] c;
            logic [31:0] pc;
            pc = {$urandom} & 32'hFFFF_FFFC;
            c  = (($urandom % 4) == 0) ? NCAUSE'($urandom) : '0;
            step(pc, pc + 32'd4, c, (($urandom % 4) == 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule